// File: doc/BRIEF.md
# Oversampled Serial Character Receiver

This block recovers asynchronous serial characters from one input line. It runs on a clock at sixteen times the bit rate. The line first passes through a two-flop synchronizer. A low level seen while idle starts a candidate frame, and the frame goes ahead only if the line is still low half a bit time later. After that, each field is sampled once at its midpoint. The host sets the word length (5 to 8 bits), the parity mode (off, odd, even, forced 1, forced 0) and whether a second stop period is checked. The receiver captures these settings when it accepts a start bit.

Each completed character goes into a single holding buffer. The receiver keeps a data-ready flag plus overrun, parity, framing and break flags. A buffer-read strobe clears the ready flag. A status-read strobe clears the four error flags. A one-cycle interrupt pulse marks every character that lands in the buffer.

Top module: `serial_char_receiver`

## Requirements
- R1: The line is synchronized through two flops. A low pulse that has ended by half a bit time (8 sample clocks) after it is detected is rejected: no character, no flag change.
- R2: The word length field selects 5 (00), 6 (01), 7 (10) or 8 (11) data bits, received LSB first. Buffer bits above the word length read 0.
- R3: Expected parity with enable=1: stick=0 and even=1 gives the XOR of the data bits; stick=0 and even=0 gives its inverse; stick=1 gives the inverse of the even bit. With enable=0 no parity bit is present.
- R4: With the extra-stop input set, a second stop sample is taken. For 6 to 8 bits it falls one bit time after the first. For 5 bits it falls at the middle of a following half bit, three quarters of a bit time after the first. A low second stop sample is a framing error.
- R5: Data-ready sets when a character completes and clears on a buffer read. A completion in the same cycle as the read wins.
- R6: A character that completes while data-ready is set and no buffer read occurs in that cycle sets the overrun flag. The buffer then holds the newer character.
- R7: The parity flag sets when parity is enabled and the received parity bit differs from the expected value.
- R8: The framing flag sets when any checked stop sample is low.
- R9: The break flag sets (with framing) when every sample of the frame is low: data zero, parity low if enabled, all stop samples low. A zero character is loaded. After any frame whose last stop sample is low, no new start is accepted until the line returns high.
- R10: A status read clears overrun, parity, framing and break, and leaves data-ready alone. A buffer read leaves the error flags alone. A flag set in the same cycle as the read stays set.
- R11: rx_irq is high for exactly one cycle per character loaded into the buffer.
- R12: After reset the buffer and all flags are 0 and rx_irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, 16x bit rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| wlen_sel | input | 2 | Word length select |
| extra_stop | input | 1 | Check a second stop period |
| par_enable | input | 1 | Parity bit present |
| par_even | input | 1 | Even-select / stick level select |
| par_stick | input | 1 | Forced parity mode |
| buf_read | input | 1 | One-cycle buffer read strobe |
| status_read | input | 1 | One-cycle status read strobe |
| rx_data | output | 8 | Received character |
| data_ready | output | 1 | Unread character in buffer |
| overrun_err | output | 1 | Character lost to overrun |
| parity_err | output | 1 | Parity mismatch seen |
| framing_err | output | 1 | Low stop sample seen |
| break_det | output | 1 | All-low frame seen |
| rx_irq | output | 1 | One-cycle pulse per loaded character |

## Verification
The bench builds the receiver with OVERSAMPLE at its default of 16. This places the start check 8 clocks after detection and the second stop sample for a 5-bit word 12 clocks after the first. With these values a 4-clock glitch can be rejected, and a stop field of one and a half bits can be driven with an 8-clock low window that only the half-bit sample sees. At this rate every frame stays short, so all word lengths, all five parity modes, break with its wait for a high line, and overrun fit into directed scenarios.

// File: rtl/serial_char_receiver.sv
`timescale 1ns/1ps
module serial_char_receiver #(
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_line,
  input  logic [1:0] wlen_sel,
  input  logic       extra_stop,
  input  logic       par_enable,
  input  logic       par_even,
  input  logic       par_stick,
  input  logic       buf_read,
  input  logic       status_read,
  output logic [7:0] rx_data,
  output logic       data_ready,
  output logic       overrun_err,
  output logic       parity_err,
  output logic       framing_err,
  output logic       break_det,
  output logic       rx_irq
);
  localparam int CW = $clog2(OVERSAMPLE);
  localparam logic [CW-1:0] LAST    = CW'(OVERSAMPLE - 1);
  localparam logic [CW-1:0] HALF_M1 = CW'(OVERSAMPLE / 2 - 1);
  localparam logic [CW-1:0] TQ_M1   = CW'((OVERSAMPLE * 3) / 4 - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_STOP2, S_HOLD} st_t;

  logic [1:0]    sync_q;
  st_t           st;
  logic [CW-1:0] cnt;
  logic [2:0]    bit_idx;
  logic [7:0]    shreg;
  logic          par_bit, stop1_q;
  logic [1:0]    wl_q;
  logic          xs_q, pe_q, ev_q, sk_q;

  wire rx_s     = sync_q[1];
  wire at_last  = (cnt == LAST);
  wire [CW-1:0] stop2_last = (wl_q == 2'b00) ? TQ_M1 : LAST;

  wire finish   = (st == S_STOP && at_last && !xs_q) ||
                  (st == S_STOP2 && cnt == stop2_last);
  wire all_stop_low = !rx_s && (st == S_STOP || !stop1_q);
  wire exp_par  = par_stick_sel(sk_q, ev_q, shreg);
  wire fe_now   = !rx_s || (st == S_STOP2 && !stop1_q);
  wire pe_now   = pe_q && (par_bit != exp_par);
  wire bi_now   = all_stop_low && (shreg == 8'h00) && (!pe_q || !par_bit);

  function automatic logic par_stick_sel(input logic sk, input logic ev, input logic [7:0] d);
    if (sk) return !ev;
    return ev ? ^d : ~^d;
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], rx_line};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; bit_idx <= '0; shreg <= '0;
      par_bit <= 1'b0; stop1_q <= 1'b1;
      wl_q <= 2'b11; xs_q <= 1'b0; pe_q <= 1'b0; ev_q <= 1'b0; sk_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE:
          if (!rx_s) begin st <= S_START; cnt <= '0; end
        S_START:
          if (cnt == HALF_M1) begin
            cnt <= '0;
            if (!rx_s) begin
              st <= S_DATA; bit_idx <= '0; shreg <= '0;
              wl_q <= wlen_sel; xs_q <= extra_stop; pe_q <= par_enable;
              ev_q <= par_even; sk_q <= par_stick;
            end else st <= S_IDLE;
          end else cnt <= cnt + 1'b1;
        S_DATA:
          if (at_last) begin
            cnt <= '0;
            shreg[bit_idx] <= rx_s;
            if (bit_idx == {1'b1, wl_q}) st <= pe_q ? S_PAR : S_STOP;
            else bit_idx <= bit_idx + 1'b1;
          end else cnt <= cnt + 1'b1;
        S_PAR:
          if (at_last) begin
            cnt <= '0; par_bit <= rx_s; st <= S_STOP;
          end else cnt <= cnt + 1'b1;
        S_STOP:
          if (at_last) begin
            cnt <= '0;
            if (xs_q) begin stop1_q <= rx_s; st <= S_STOP2; end
            else st <= rx_s ? S_IDLE : S_HOLD;
          end else cnt <= cnt + 1'b1;
        S_STOP2:
          if (cnt == stop2_last) begin
            cnt <= '0; st <= rx_s ? S_IDLE : S_HOLD;
          end else cnt <= cnt + 1'b1;
        S_HOLD:
          if (rx_s) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data <= '0; data_ready <= 1'b0; overrun_err <= 1'b0;
      parity_err <= 1'b0; framing_err <= 1'b0; break_det <= 1'b0; rx_irq <= 1'b0;
    end else begin
      rx_irq <= finish;
      if (finish) rx_data <= shreg;

      if (finish)        data_ready <= 1'b1;
      else if (buf_read) data_ready <= 1'b0;

      if (finish && data_ready && !buf_read) overrun_err <= 1'b1;
      else if (status_read)                  overrun_err <= 1'b0;

      if (finish && pe_now)  parity_err <= 1'b1;
      else if (status_read)  parity_err <= 1'b0;

      if (finish && fe_now)  framing_err <= 1'b1;
      else if (status_read)  framing_err <= 1'b0;

      if (finish && bi_now)  break_det <= 1'b1;
      else if (status_read)  break_det <= 1'b0;
    end
  end

  // R5
  ready_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_read && !finish |=> !data_ready);

  // R6
  overrun_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun_err) |-> $past(data_ready));

  // R9
  break_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    break_det |-> framing_err);

  // R11
  irq_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> data_ready);

  // R10
  stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_read && !finish |=> !(overrun_err || parity_err || framing_err || break_det));

  // R2
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    finish && wl_q == 2'b00 |=> rx_data[7:5] == 3'b000);
endmodule

// File: tb/serial_char_receiver_test.sv
`timescale 1ns/1ps
module serial_char_receiver_test;
  logic clk = 1'b0, rst_n = 1'b0, rx = 1'b1;
  logic [1:0] wlen = 2'b11;
  logic xstop = 0, pen = 0, pev = 0, psk = 0, brd = 0, srd = 0;
  logic [7:0] dout;
  logic rdy, oe, pe, fe, bi, irq;
  int checks = 0, fails = 0, irqs = 0;
  bit done = 0;

  always #2 clk = ~clk;

  serial_char_receiver #(.OVERSAMPLE(16)) uut (
    .clk(clk), .rst_n(rst_n), .rx_line(rx), .wlen_sel(wlen), .extra_stop(xstop),
    .par_enable(pen), .par_even(pev), .par_stick(psk), .buf_read(brd), .status_read(srd),
    .rx_data(dout), .data_ready(rdy), .overrun_err(oe), .parity_err(pe),
    .framing_err(fe), .break_det(bi), .rx_irq(irq));

  always @(negedge clk) if (irq) irqs++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // flags packed as {ready, overrun, parity, framing, break}
  function automatic logic [4:0] flags();
    return {rdy, oe, pe, fe, bi};
  endfunction

  task automatic hold_line(input logic lvl, input int n);
    rx = lvl;
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input logic [7:0] d, input int nb, input bit hp, input logic pb,
                       input logic s1, input int xclk, input logic s2);
    hold_line(1'b0, 16);
    for (int i = 0; i < nb; i++) hold_line(d[i], 16);
    if (hp) hold_line(pb, 16);
    hold_line(s1, 16);
    if (xclk > 0) hold_line(s2, xclk);
    hold_line(1'b1, 24);
  endtask

  task automatic rd_buf();  brd = 1; @(negedge clk); brd = 0; @(negedge clk); endtask
  task automatic rd_stat(); srd = 1; @(negedge clk); srd = 0; @(negedge clk); endtask
  task automatic clear_all(); rd_buf(); rd_stat(); endtask

  task automatic setcfg(input logic [1:0] w, input logic x, input logic e, input logic v, input logic s);
    wlen = w; xstop = x; pen = e; pev = v; psk = s;
  endtask

  task automatic t_reset();
    chk("R12 flags", flags(), 5'b0);
    chk("R12 data", dout, 8'h00);
    chk("R12 irq", irq, 1'b0);
  endtask

  task automatic t_basic();
    int i0 = irqs;
    setcfg(2'b11, 0, 0, 0, 0);
    frame(8'hA5, 8, 0, 0, 1, 0, 1);
    chk("R2 8-bit data", dout, 8'hA5);
    chk("R5 ready set", flags(), 5'b10000);
    chk("R11 one pulse", irqs - i0, 1);
    rd_buf();
    chk("R5 ready cleared", rdy, 1'b0);
  endtask

  task automatic t_wlen();
    setcfg(2'b00, 0, 0, 0, 0);
    frame(8'hF6, 5, 0, 0, 1, 0, 1);
    chk("R2 5-bit", dout, 8'h16);
    rd_buf();
    setcfg(2'b01, 0, 0, 0, 0);
    frame(8'h2B, 6, 0, 0, 1, 0, 1);
    chk("R2 6-bit", dout, 8'h2B);
    rd_buf();
    setcfg(2'b10, 0, 0, 0, 0);
    frame(8'h5A, 7, 0, 0, 1, 0, 1);
    chk("R2 7-bit", dout, 8'h5A);
    rd_buf();
  endtask

  task automatic t_parity();
    setcfg(2'b10, 0, 1, 1, 0);
    frame(8'h5A, 7, 1, ^8'h5A, 1, 0, 1);
    chk("R3 even ok", flags(), 5'b10000);
    rd_buf();
    frame(8'h5A, 7, 1, ~^8'h5A, 1, 0, 1);
    chk("R7 even mismatch", flags(), 5'b10100);
    rd_buf();
    chk("R10 buf read keeps pe", flags(), 5'b00100);
    rd_stat();
    chk("R10 stat read clears pe", flags(), 5'b00000);
    setcfg(2'b11, 0, 1, 0, 0);
    frame(8'h03, 8, 1, ~^8'h03, 1, 0, 1);
    chk("R3 odd ok", flags(), 5'b10000);
    clear_all();
  endtask

  task automatic t_stick();
    setcfg(2'b11, 0, 1, 0, 1);
    frame(8'h00, 8, 1, 0, 1, 0, 1);
    chk("R3 stick one, got zero", pe, 1'b1);
    clear_all();
    frame(8'h00, 8, 1, 1, 1, 0, 1);
    chk("R3 stick one ok", pe, 1'b0);
    clear_all();
    setcfg(2'b11, 0, 1, 1, 1);
    frame(8'hFF, 8, 1, 0, 1, 0, 1);
    chk("R3 stick zero ok", pe, 1'b0);
    clear_all();
  endtask

  task automatic t_framing();
    setcfg(2'b11, 0, 0, 0, 0);
    frame(8'h3C, 8, 0, 0, 0, 0, 1);
    chk("R8 framing", flags(), 5'b10010);
    chk("R8 data", dout, 8'h3C);
    rd_stat();
    chk("R10 stat keeps ready", flags(), 5'b10000);
    rd_buf();
  endtask

  task automatic t_overrun();
    setcfg(2'b11, 0, 0, 0, 0);
    frame(8'h11, 8, 0, 0, 1, 0, 1);
    frame(8'h22, 8, 0, 0, 1, 0, 1);
    chk("R6 overrun", flags(), 5'b11000);
    chk("R6 newer kept", dout, 8'h22);
    rd_buf();
    chk("R10 buf read keeps oe", oe, 1'b1);
    rd_stat();
    chk("R10 oe cleared", oe, 1'b0);
  endtask

  task automatic t_break();
    int i0 = irqs;
    setcfg(2'b11, 0, 0, 0, 0);
    hold_line(1'b0, 16 * 10 + 60);
    hold_line(1'b1, 24);
    chk("R9 break flags", flags(), 5'b10011);
    chk("R9 zero char", dout, 8'h00);
    chk("R9 single char while low", irqs - i0, 1);
    clear_all();
  endtask

  task automatic t_glitch();
    int i0 = irqs;
    hold_line(1'b0, 4);
    hold_line(1'b1, 40);
    chk("R1 glitch no char", irqs - i0, 0);
    chk("R1 glitch no flags", flags(), 5'b0);
  endtask

  task automatic t_stop2();
    setcfg(2'b11, 1, 0, 0, 0);
    frame(8'h81, 8, 0, 0, 1, 16, 1);
    chk("R4 two stops ok", flags(), 5'b10000);
    clear_all();
    frame(8'h81, 8, 0, 0, 1, 16, 0);
    chk("R4 second stop low", flags(), 5'b10010);
    clear_all();
    setcfg(2'b00, 1, 0, 0, 0);
    frame(8'h0D, 5, 0, 0, 1, 8, 0);
    chk("R4 half stop low", fe, 1'b1);
    chk("R4 half stop data", dout, 8'h0D);
    clear_all();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_basic();
    t_wlen();
    t_parity();
    t_stick();
    t_framing();
    t_overrun();
    t_break();
    t_glitch();
    t_stop2();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule